// File: doc/BRIEF.md
# Factorial Sequencer with Custom Datapath

This block works out the factorial of an unsigned 8-bit operand. A Moore control unit with five states steers a small datapath. The datapath holds a product register, a down counter that loads the operand in parallel, a multiplier, and a comparator that tests whether the counter is above one. A start strobe launches a run. The block loads the operand, then alternates between a test step and a multiply-and-decrement step until the counter reaches one or less. After that it presents the product for exactly one cycle and returns to idle.

Outside the presentation cycle, the result bus is held at zero and an output enable is low. An enclosing design can turn the data bus and the enable into a shared tri-state bus. The product register is 32 bits wide and silently wraps, so results are exact up to 12!.

Top module: `fact_engine`

## Requirements
- R1: While rstN is low (asynchronous, active low), doneOut and resultEn are 0 and resultOut is 0. This holds also when reset arrives in the middle of a run, and a later run still gives correct results.
- R2: While idle with startReq low, the block stays idle: doneOut and resultEn stay 0 and resultOut stays 0.
- R3: The value presented equals n! modulo 2^32, where n is nIn sampled in the cycle after the start edge. Operands 0 and 1 both give 1, and 13! appears truncated as 1932053504.
- R4: Let k = max(n-1, 0). doneOut is high in the cycle that begins 2k+2 rising edges after the edge that samples startReq high in idle.
- R5: doneOut is high for exactly one cycle per run. resultEn is high in exactly that cycle, and resultOut is 0 whenever resultEn is 0.
- R6: While a run is in progress, changes on startReq and nIn have no effect on the result or on when it appears. After the presentation cycle the block does not restart unless startReq is high in idle.
- R7: If startReq is held high, the block restarts from idle after every run, so done pulses repeat every 2k+4 cycles with the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Launches a run when sampled high in idle |
| nIn | input | 8 | Operand whose factorial is computed |
| doneOut | output | 1 | High for the single cycle that presents the result |
| resultEn | output | 1 | Output enable for the result bus |
| resultOut | output | 32 | Product, truncated to 32 bits; 0 when not enabled |

## Verification
Two things happen in the same cycle: the multiply and the decrement. Both update on one edge and must read the old count. The bench provokes this with every operand from 0 to 13 and with 255. It compares the presented product against a reference loop, so a decrement that saw the new count, or a multiply that did, would shift the product by one factor. A start request arriving during the multiply phase, and a start held through the presentation cycle, also coincide with datapath steps. These are judged by the result value and by the exact edge on which done rises.

// File: rtl/fact_pkg.sv
package fact_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_LOAD = 3'b001,
    ST_TEST = 3'b010,
    ST_MUL  = 3'b011,
    ST_DONE = 3'b100
  } fact_state_e;

  typedef struct packed {
    logic loadN;    // load counter from operand, set product to one
    logic mulStep;  // product *= count, count -= 1
    logic outEn;    // present product on the result bus
  } fact_ctrl_t;

endpackage

// File: rtl/fact_ctrl.sv
module fact_ctrl
  import fact_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       gtOne,
  output fact_ctrl_t ctl,
  output logic       doneOut
);

  fact_state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    case (state)
      ST_IDLE: stateNext = startReq ? ST_LOAD : ST_IDLE;
      ST_LOAD: stateNext = ST_TEST;
      ST_TEST: stateNext = gtOne ? ST_MUL : ST_DONE;
      ST_MUL:  stateNext = ST_TEST;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.loadN   = (state == ST_LOAD);
    ctl.mulStep = (state == ST_MUL);
    ctl.outEn   = (state == ST_DONE);
    doneOut     = (state == ST_DONE);
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_IDLE));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq) |=> (state == ST_LOAD));

  // R6
  mul_after_test_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateNext == ST_MUL) |-> (state == ST_TEST && gtOne));

endmodule

// File: rtl/fact_dp.sv
module fact_dp
  import fact_pkg::*;
#(
  parameter int N_W = 8,
  parameter int P_W = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  fact_ctrl_t     ctl,
  input  logic [N_W-1:0] nIn,
  output logic           gtOne,
  output logic [P_W-1:0] resultOut
);

  localparam logic [P_W-1:0] PROD_ONE = P_W'(1);

  logic [N_W-1:0] cnt;
  logic [P_W-1:0] prod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      prod <= '0;
    end else if (ctl.loadN) begin
      cnt  <= nIn;
      prod <= PROD_ONE;
    end else if (ctl.mulStep) begin
      prod <= prod * P_W'(cnt);
      cnt  <= cnt - 1'b1;
    end
  end

  assign gtOne     = (cnt > N_W'(1));
  assign resultOut = ctl.outEn ? prod : '0;

  // R3
  mul_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mulStep |=> (cnt == $past(cnt) - 1'b1));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadN && !ctl.mulStep) |=> ($stable(cnt) && $stable(prod)));

  // R4
  finish_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.outEn |-> !gtOne);

endmodule

// File: rtl/fact_engine.sv
module fact_engine
  import fact_pkg::*;
#(
  parameter int N_W = 8,
  parameter int P_W = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startReq,
  input  logic [N_W-1:0] nIn,
  output logic           doneOut,
  output logic           resultEn,
  output logic [P_W-1:0] resultOut
);

  fact_ctrl_t ctl;
  logic       gtOne;

  fact_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .gtOne    (gtOne),
    .ctl      (ctl),
    .doneOut  (doneOut)
  );

  fact_dp #(.N_W(N_W), .P_W(P_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .nIn       (nIn),
    .gtOne     (gtOne),
    .resultOut (resultOut)
  );

  assign resultEn = ctl.outEn;

  // R5
  en_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultEn == doneOut) && (resultEn || resultOut == '0));

endmodule

// File: tb/fact_engine_bench.sv
`timescale 1ns/1ps
module fact_engine_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [7:0]  nIn = '0;
  logic        doneOut, resultEn;
  logic [31:0] resultOut;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  fact_engine u_fact_engine (
    .clk(clk), .rstN(rstN), .startReq(startReq), .nIn(nIn),
    .doneOut(doneOut), .resultEn(resultEn), .resultOut(resultOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refFact(input int n);
    logic [31:0] p = 32'd1;
    for (int i = 2; i <= n; i++) p = p * 32'(i);
    return p;
  endfunction

  function automatic int stepsOf(input int n);
    return (n > 1) ? n - 1 : 0;
  endfunction

  task automatic checkIdle(input string req);
    check(doneOut == 1'b0, req, doneOut, 0);
    check(resultEn == 1'b0, req, resultEn, 0);
    check(resultOut == 32'd0, req, resultOut, 0);
  endtask

  // R3 R4 R5: one run, latency, value, single-cycle done
  task automatic runCase(input int n);
    int cyc = 0;
    int k = stepsOf(n);
    @(negedge clk);
    nIn = 8'(n);
    startReq = 1'b1;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) startReq = 1'b0;
    end while (!doneOut && cyc < 700);
    check(cyc == 3 + 2 * k, "R4 latency", cyc, 3 + 2 * k);
    check(resultOut == refFact(n), "R3 value", resultOut, refFact(n));
    check(resultEn == 1'b1, "R5 enable", resultEn, 1);
    @(negedge clk);
    checkIdle("R5 one-cycle");
  endtask

  task automatic testReset();
    rstN = 1'b0;
    #1;
    checkIdle("R1 reset");
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    checkIdle("R2 idle");
  endtask

  // R6: start and operand changes during a run
  task automatic testBusyIgnore();
    int cyc = 0;
    @(negedge clk);
    nIn = 8'd5;
    startReq = 1'b1;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) startReq = 1'b0;
      if (cyc == 4) begin startReq = 1'b1; nIn = 8'd200; end
      if (cyc == 6) startReq = 1'b0;
    end while (!doneOut && cyc < 100);
    check(cyc == 11, "R6 timing", cyc, 11);
    check(resultOut == 32'd120, "R6 value", resultOut, 120);
    repeat (2) @(negedge clk);
    checkIdle("R6 no restart");
  endtask

  // R7: start held high
  task automatic testHold();
    int cyc = 0;
    int first = 0;
    int second = 0;
    @(negedge clk);
    nIn = 8'd3;
    startReq = 1'b1;
    while (second == 0 && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (doneOut) begin
        check(resultOut == 32'd6, "R7 value", resultOut, 6);
        if (first == 0) first = cyc; else second = cyc;
      end
    end
    startReq = 1'b0;
    check(first == 7, "R7 first", first, 7);
    check(second - first == 8, "R7 period", second - first, 8);
    repeat (4) @(negedge clk);
    checkIdle("R7 release");
  endtask

  // R1: reset in the middle of a run
  task automatic testMidReset();
    @(negedge clk);
    nIn = 8'd6;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    #1;
    checkIdle("R1 mid reset");
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    checkIdle("R1 after reset");
    runCase(4);
  endtask

  initial begin
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    for (int n = 0; n <= 13; n++) runCase(n);
    runCase(255);
    testBusyIgnore();
    testHold();
    testMidReset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule